// File: doc/BRIEF.md
# Descriptor-Driven Single-Block Copy Engine

This block is one channel of a memory-to-memory copy engine. A start pulse passes it the address of a transfer descriptor in memory. The engine reads the 48-byte descriptor through its own memory master port as three 16-byte reads. It then copies a run of equal-width elements from a source region to a destination region. Each element is one read followed by one write. After every element, the source and destination addresses each move by their own signed byte step.

When the job ends, the engine raises a one-cycle completion pulse and returns to idle. A job can end normally, on a misaligned element address, or on a memory error response. A four-bit error field tells how the job ended, and it holds its value until the next accepted start.

Descriptors can be addressed in two ways. With the full-address flag set, the start address is used as given. Otherwise the top 12 bits come from a page input, so all descriptors lie in one 1 MB window.

Top module: `dfc_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `err_flags` are all zero.
- R2: A start accepted while idle issues three 16-byte reads (`mem_size` = 4) at base, base+16 and base+32. The low four bits of `start_addr` are ignored, so the base is always 16-byte aligned.
- R3: With `start_full` = 1 the base comes from all 32 bits of `start_addr`. With `start_full` = 0 its bits 31:20 are `desc_page` and its bits 19:4 are `start_addr[19:4]`.
- R4: Descriptor bytes are little-endian: byte k of the descriptor is at base+k. The engine uses these fields:
  - element count minus one: 16 bits at byte 0
  - signed source step: 32 bits at byte 4
  - source address: 32 bits at byte 12
  - source access word: 16 bits at byte 20, with the element size code in bits 5:3
  - signed destination step: 32 bits at byte 36
  - destination address: 32 bits at byte 44
- R5: The engine copies count+1 elements. For each element it reads at the source address, then writes the same bytes at the destination address. After each element, each address adds its own step (two's-complement, so negative steps move downward).
- R6: Size code 0, 1, 2, 3 or 4 selects an element of 1, 2, 4, 8 or 16 bytes, and codes 5 to 7 act as 4. The code is driven on `mem_size` for data accesses. Element bytes travel right-aligned on the data buses: byte j is in bits 8j+7:8j.
- R7: `done` is high for exactly one cycle at the end of a job, and `busy` is low in the cycle after it. `err_flags` holds its value until the next accepted start, which clears it.
- R8: Before each element, the engine checks both addresses against the element size. A misaligned source sets `err_flags[1]` and a misaligned destination sets `err_flags[0]`. The job then ends without touching that element, and elements already written stay in place.
- R9: An error response (`mem_err` with `mem_ack`) to a descriptor read sets `err_flags[2]`. The job then ends with no data read or written.
- R10: An error response to a data read or write sets `err_flags[3]` and ends the job.
- R11: A start pulse while `busy` is high is ignored. The running job completes unchanged and no second job follows.
- R12: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_size` unchanged until the cycle that `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | 32 | Descriptor address |
| start_full | input | 1 | 1: use all address bits; 0: take the upper bits from `desc_page` |
| desc_page | input | 12 | Upper address bits used for descriptors when `start_full` is 0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 3 | Access size code (bytes = 2^code) |
| mem_wdata | output | 128 | Write data, right-aligned |
| mem_ack | input | 1 | Access accepted; read data and error are valid |
| mem_rdata | input | 128 | Read data, right-aligned |
| mem_err | input | 1 | Error response, qualified by `mem_ack` |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_flags | output | 4 | [0] dest misaligned, [1] source misaligned, [2] descriptor read error, [3] data access error |

## Verification
The properties assume a memory that raises `mem_ack` only while a request is pending, for one cycle per request, and asserts `mem_err` only together with `mem_ack`. The alignment property assumes every address the engine issues is a multiple of its access size. That holds only because misaligned elements are refused before any request goes out.

The bench memory model acknowledges one cycle after it first sees a request and never acknowledges twice in a row. It injects errors only at one chosen address. It also keeps its own count of any request that was dropped or changed before its acknowledge.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int ADDR_W     = 32;
    localparam int BEAT_BYTES = 16;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int DESC_BEATS = 3;
    localparam int BLOB_W     = DESC_BEATS * BEAT_W;
    localparam int BEAT_IW    = $clog2(DESC_BEATS);
    localparam int SIZE_W     = 3;
    localparam int MAX_SIZE   = 4;
    localparam int CNT_W      = 16;

    localparam int ERR_W      = 4;
    localparam int ERR_UWR    = 0;
    localparam int ERR_URD    = 1;
    localparam int ERR_DESC   = 2;
    localparam int ERR_DATA   = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_RD,
        S_WR,
        S_FIN
    } dfc_state_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] smod;
        logic [ADDR_W-1:0] saddr;
        logic [ADDR_W-1:0] dmod;
        logic [ADDR_W-1:0] daddr;
        logic [SIZE_W-1:0] size;
    } dfc_job_t;

endpackage

// File: rtl/dfc_desc_decode.sv
module dfc_desc_decode
    import dfc_pkg::*;
(
    input  logic [BLOB_W-1:0] blob,
    output dfc_job_t          job
);
    localparam int OFS_CNT   = 0;
    localparam int OFS_SSTEP = 4;
    localparam int OFS_SADDR = 12;
    localparam int OFS_SACC  = 20;
    localparam int OFS_DSTEP = 36;
    localparam int OFS_DADDR = 44;
    localparam int SIZE_LSB  = 3;

    logic [15:0]       acc_word;
    logic [SIZE_W-1:0] raw_size;

    always_comb begin
        acc_word  = blob[8*OFS_SACC +: 16];
        raw_size  = acc_word[SIZE_LSB +: SIZE_W];
        job.cnt   = blob[8*OFS_CNT +: CNT_W];
        job.smod  = blob[8*OFS_SSTEP +: ADDR_W];
        job.saddr = blob[8*OFS_SADDR +: ADDR_W];
        job.dmod  = blob[8*OFS_DSTEP +: ADDR_W];
        job.daddr = blob[8*OFS_DADDR +: ADDR_W];
        job.size  = (raw_size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : raw_size;
    end
endmodule

// File: rtl/dfc_align_chk.sv
module dfc_align_chk
    import dfc_pkg::*;
(
    input  logic [3:0]        src_lo,
    input  logic [3:0]        dst_lo,
    input  logic [SIZE_W-1:0] size,
    output logic              src_bad,
    output logic              dst_bad
);
    logic [4:0] span;
    logic [3:0] lo_mask;

    always_comb begin
        span    = 5'd1 << size;
        lo_mask = 4'(span - 5'd1);
        src_bad = |(src_lo & lo_mask);
        dst_bad = |(dst_lo & lo_mask);
    end
endmodule

// File: rtl/dfc_copy_engine.sv
module dfc_copy_engine
    import dfc_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 start_full,
    input  logic [PAGE_W-1:0]    desc_page,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [SIZE_W-1:0]    mem_size,
    output logic [BEAT_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [BEAT_W-1:0]    mem_rdata,
    input  logic                 mem_err,
    output logic                 busy,
    output logic                 done,
    output logic [ERR_W-1:0]     err_flags
);
    localparam int OFF_W = ADDR_W - PAGE_W;

    typedef struct packed {
        dfc_state_e          st;
        logic [BEAT_IW-1:0]  beat;
        logic [BLOB_W-1:0]   blob;
        logic [ADDR_W-1:0]   base;
        dfc_job_t            job;
        logic [BEAT_W-1:0]   data;
        logic [ERR_W-1:0]    err;
    } regs_t;

    regs_t    q, n;
    dfc_job_t dec_job;
    logic     src_bad, dst_bad;

    dfc_desc_decode u_dec (
        .blob (q.blob),
        .job  (dec_job)
    );

    dfc_align_chk u_align (
        .src_lo  (q.job.saddr[3:0]),
        .dst_lo  (q.job.daddr[3:0]),
        .size    (q.job.size),
        .src_bad (src_bad),
        .dst_bad (dst_bad)
    );

    always_comb begin
        n         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = '0;
        mem_wdata = '0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.st   = S_FETCH;
                    n.beat = '0;
                    n.err  = '0;
                    n.base = start_full ? {start_addr[ADDR_W-1:4], 4'h0}
                                        : {desc_page, start_addr[OFF_W-1:4], 4'h0};
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.base + (ADDR_W'(q.beat) << 4);
                mem_size = SIZE_W'(MAX_SIZE);
                if (mem_ack) begin
                    if (mem_err) begin
                        n.err[ERR_DESC] = 1'b1;
                        n.st            = S_FIN;
                    end else begin
                        n.blob[q.beat*BEAT_W +: BEAT_W] = mem_rdata;
                        if (q.beat == BEAT_IW'(DESC_BEATS-1)) begin
                            n.st = S_LOAD;
                        end else begin
                            n.beat = q.beat + 1'b1;
                        end
                    end
                end
            end
            S_LOAD: begin
                n.job = dec_job;
                n.st  = S_RD;
            end
            S_RD: begin
                if (src_bad || dst_bad) begin
                    n.err[ERR_URD] = src_bad;
                    n.err[ERR_UWR] = dst_bad;
                    n.st           = S_FIN;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = q.job.saddr;
                    mem_size = q.job.size;
                    if (mem_ack) begin
                        if (mem_err) begin
                            n.err[ERR_DATA] = 1'b1;
                            n.st            = S_FIN;
                        end else begin
                            n.data = mem_rdata;
                            n.st   = S_WR;
                        end
                    end
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.job.daddr;
                mem_size  = q.job.size;
                mem_wdata = q.data;
                if (mem_ack) begin
                    if (mem_err) begin
                        n.err[ERR_DATA] = 1'b1;
                        n.st            = S_FIN;
                    end else begin
                        n.job.saddr = q.job.saddr + q.job.smod;
                        n.job.daddr = q.job.daddr + q.job.dmod;
                        if (q.job.cnt == '0) begin
                            n.st = S_FIN;
                        end else begin
                            n.job.cnt = q.job.cnt - 1'b1;
                            n.st      = S_RD;
                        end
                    end
                end
            end
            S_FIN: begin
                n.st = S_IDLE;
            end
            default: begin
                n.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_FIN);
    assign err_flags = q.err;

endmodule

// File: rtl/dfc_copy_chk.sv
module dfc_copy_chk
    import dfc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               mem_req,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [SIZE_W-1:0]  mem_size,
    input logic               mem_ack,
    input logic               busy,
    input logic               done,
    input logic [ERR_W-1:0]   err_flags
);
    logic [ADDR_W-1:0] size_mask;
    assign size_mask = (ADDR_W'(1) << mem_size) - ADDR_W'(1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)); // R12

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & size_mask) == '0)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R7

    AST_DESC_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[ERR_DESC] |-> !mem_req); // R9

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy); // R11

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R1
endmodule

bind dfc_copy_engine dfc_copy_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done),
    .err_flags (err_flags)
);

// File: tb/sim_dfc_copy_engine.sv
`timescale 1ns/1ps
module sim_dfc_copy_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  start_addr = '0;
    logic         start_full = 1'b1;
    logic [11:0]  desc_page = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [2:0]   mem_size;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic         mem_err = 1'b0;
    logic         busy, done;
    logic [3:0]   err_flags;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    dfc_copy_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_full(start_full), .desc_page(desc_page),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .busy(busy), .done(done), .err_flags(err_flags)
    );

    // memory model: 4 KB, addresses wrap on 12 bits
    logic [7:0]  mem [0:4095];
    logic [31:0] rlog [0:63];
    int          rcnt = 0;
    int          wcnt = 0;
    int          proto_bad = 0;
    bit          err_on = 1'b0;
    logic [31:0] err_addr = '0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr;
    logic        pend_we;
    logic [2:0]  pend_size;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            pend = 1'b0;
        end else begin
            if (pend && !(mem_req && mem_addr == pend_addr && mem_we == pend_we && mem_size == pend_size))
                proto_bad++;
            if (mem_req && !mem_ack) begin
                logic [127:0] rv;
                bit hit;
                pend = 1'b1; pend_addr = mem_addr; pend_we = mem_we; pend_size = mem_size;
                hit = err_on && (mem_addr == err_addr);
                mem_ack <= 1'b1;
                mem_err <= hit;
                rv = '0;
                if (mem_we) begin
                    wcnt++;
                    if (!hit)
                        for (int k = 0; k < (1 << mem_size); k++)
                            mem[12'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
                end else begin
                    rlog[rcnt[5:0]] = mem_addr;
                    rcnt++;
                    for (int k = 0; k < (1 << mem_size); k++)
                        rv[8*k +: 8] = mem[12'(mem_addr + 32'(k))];
                end
                mem_rdata <= rv;
            end else begin
                pend = 1'b0;
                mem_ack <= 1'b0;
                mem_err <= 1'b0;
            end
        end
    end

    function automatic logic [7:0] pat(input logic [11:0] a);
        return (a[7:0] ^ 8'h5A) + {4'h0, a[11:8]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int a = 0; a < 4096; a++) mem[a] = (a >= 'hC00) ? 8'h00 : pat(12'(a));
        rcnt = 0; wcnt = 0; err_on = 1'b0;
    endtask

    task automatic put16(input int a, input logic [15:0] v);
        mem[12'(a)] = v[7:0]; mem[12'(a+1)] = v[15:8];
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[12'(a+k)] = v[8*k +: 8];
    endtask

    task automatic put_desc(input int b, input logic [15:0] cnt, input logic [31:0] smod,
                            input logic [31:0] sa, input logic [2:0] code,
                            input logic [31:0] dmod, input logic [31:0] da);
        for (int k = 0; k < 48; k++) mem[12'(b+k)] = 8'h00;
        put16(b + 0, cnt);
        put32(b + 4, smod);
        put32(b + 12, sa);
        put16(b + 20, {10'h0, code, 3'h0});
        put32(b + 36, dmod);
        put32(b + 44, da);
    endtask

    task automatic run_job(input logic [31:0] a, input bit full, input logic [11:0] pg,
                           output logic [3:0] e);
        int t;
        @(negedge clk);
        start_addr = a; start_full = full; desc_page = pg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
        e = err_flags;
        @(negedge clk);
        chk(!busy && !done, "R7 idle after done", {30'h0, busy, done}, 32'd0);
    endtask

    function automatic int copy_bad(input int n, input int eb, input logic [31:0] s, input logic [31:0] sm,
                                    input logic [31:0] d, input logic [31:0] dm);
        int bad = 0;
        logic [31:0] sa = s, da = d;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < eb; k++)
                if (mem[12'(da + 32'(k))] !== pat(12'(sa + 32'(k)))) bad++;
            sa = sa + sm; da = da + dm;
        end
        return bad;
    endfunction

    task automatic t_reset();
        chk(!busy && !done && !mem_req && err_flags == 4'h0, "R1 reset state",
            {27'h0, busy, done, mem_req, 2'h0} | 32'(err_flags), 32'd0);
    endtask

    task automatic t_basic();
        logic [3:0] e;
        init_mem();
        put_desc('h100, 16'd3, 32'd4, 32'h400, 3'd2, 32'd4, 32'hC00);
        run_job(32'h12345107, 1'b1, 12'h000, e);
        chk(rlog[0] == 32'h12345100, "R2 R3 first fetch", rlog[0], 32'h12345100);
        chk(rlog[1] == 32'h12345110 && rlog[2] == 32'h12345120, "R2 next fetches", rlog[2], 32'h12345120);
        chk(e == 4'h0, "R5 no error", 32'(e), 32'd0);
        chk(copy_bad(4, 4, 32'h400, 4, 32'hC00, 4) == 0, "R4 R5 copy 4x4B",
            32'(copy_bad(4, 4, 32'h400, 4, 32'hC00, 4)), 32'd0);
        chk(rcnt == 7 && wcnt == 4, "R5 access counts", 32'(rcnt*100 + wcnt), 32'd704);
        repeat (4) @(negedge clk);
        chk(err_flags == 4'h0, "R7 flags hold", 32'(err_flags), 32'd0);
    endtask

    task automatic t_page();
        logic [3:0] e;
        init_mem();
        put_desc('h200, 16'd0, 32'd1, 32'h455, 3'd0, 32'd1, 32'hC10);
        run_job(32'hFFF00208, 1'b0, 12'hABC, e);
        chk(rlog[0] == 32'hABC00200, "R3 paged fetch", rlog[0], 32'hABC00200);
        chk(e == 4'h0 && mem[12'hC10] == pat(12'h455), "R3 paged copy", {24'h0, mem[12'hC10]}, {24'h0, pat(12'h455)});
    endtask

    task automatic t_sizes();
        logic [3:0] e;
        init_mem();
        put_desc('h100, 16'd2, 32'd3, 32'h501, 3'd0, 32'd1, 32'hC20);
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'h0 && copy_bad(3, 1, 32'h501, 3, 32'hC20, 1) == 0, "R6 byte elements stride 3",
            32'(copy_bad(3, 1, 32'h501, 3, 32'hC20, 1)), 32'd0);
        init_mem();
        put_desc('h100, 16'd1, 32'd16, 32'h600, 3'd4, 32'd32, 32'hC40);
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'h0 && copy_bad(2, 16, 32'h600, 16, 32'hC40, 32) == 0, "R6 16-byte elements",
            32'(copy_bad(2, 16, 32'h600, 16, 32'hC40, 32)), 32'd0);
        init_mem();
        put_desc('h100, 16'd0, 32'd16, 32'h700, 3'd7, 32'd16, 32'hC80);
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'h0 && copy_bad(1, 16, 32'h700, 16, 32'hC80, 16) == 0 && mem[12'hC90] == 8'h00,
            "R6 code 7 acts as 16B", {24'h0, mem[12'hC90]}, 32'd0);
    endtask

    task automatic t_negstep();
        logic [3:0] e;
        init_mem();
        put_desc('h100, 16'd2, 32'hFFFFFFF8, 32'h810, 3'd3, 32'd8, 32'hD00);
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'h0 && copy_bad(3, 8, 32'h810, 32'hFFFFFFF8, 32'hD00, 8) == 0, "R5 negative step",
            32'(copy_bad(3, 8, 32'h810, 32'hFFFFFFF8, 32'hD00, 8)), 32'd0);
    endtask

    task automatic t_unaligned();
        logic [3:0] e;
        init_mem();
        put_desc('h100, 16'd1, 32'd4, 32'h402, 3'd2, 32'd4, 32'hC00);
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'b0010, "R8 source misaligned", 32'(e), 32'h2);
        chk(wcnt == 0 && rcnt == 3, "R8 no data access", 32'(rcnt*100 + wcnt), 32'd300);
        init_mem();
        put_desc('h100, 16'd2, 32'd4, 32'h400, 3'd2, 32'd6, 32'hE00);
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'b0001, "R8 dest misaligned", 32'(e), 32'h1);
        chk(copy_bad(1, 4, 32'h400, 4, 32'hE00, 6) == 0 && wcnt == 1 && mem[12'hE06] == 8'h00,
            "R8 earlier element kept", 32'(wcnt), 32'd1);
    endtask

    task automatic t_desc_err();
        logic [3:0] e;
        init_mem();
        put_desc('h100, 16'd3, 32'd4, 32'h400, 3'd2, 32'd4, 32'hC00);
        err_on = 1'b1; err_addr = 32'h110;
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'b0100, "R9 descriptor error", 32'(e), 32'h4);
        chk(wcnt == 0 && rcnt == 2, "R9 no data access", 32'(rcnt*100 + wcnt), 32'd200);
        err_on = 1'b0;
        @(negedge clk);
        start = 1'b1; start_addr = 32'h100; start_full = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err_flags == 4'h0, "R7 flags cleared by start", 32'(err_flags), 32'd0);
        while (busy) @(negedge clk);
    endtask

    task automatic t_data_err();
        logic [3:0] e;
        init_mem();
        put_desc('h100, 16'd3, 32'd4, 32'h400, 3'd2, 32'd4, 32'hF00);
        err_on = 1'b1; err_addr = 32'hF04;
        run_job(32'h100, 1'b1, 12'h0, e);
        chk(e == 4'b1000, "R10 data error", 32'(e), 32'h8);
        chk(wcnt == 2 && rcnt == 5, "R10 job stopped", 32'(rcnt*100 + wcnt), 32'd502);
        err_on = 1'b0;
    endtask

    task automatic t_busy_start();
        int t;
        init_mem();
        put_desc('h100, 16'd3, 32'd4, 32'h400, 3'd2, 32'd4, 32'hC00);
        put_desc('h200, 16'd0, 32'd4, 32'h500, 3'd2, 32'd4, 32'hD00);
        @(negedge clk);
        start = 1'b1; start_addr = 32'h100; start_full = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; start_addr = 32'h200;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        repeat (6) @(negedge clk);
        chk(!busy && rcnt == 7 && wcnt == 4, "R11 start while busy ignored", 32'(rcnt*100 + wcnt), 32'd704);
        chk(copy_bad(4, 4, 32'h400, 4, 32'hC00, 4) == 0 && mem[12'hD00] == 8'h00, "R11 first job intact",
            {24'h0, mem[12'hD00]}, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_page();
        t_sizes();
        t_negstep();
        t_unaligned();
        t_desc_err();
        t_data_err();
        t_busy_start();
        chk(proto_bad == 0, "R12 request held until ack", 32'(proto_bad), 32'd0);
        summary();
        $finish;
    end
endmodule